// File: doc/BRIEF.md
# Floppy Controller Host-Side Request Sequencer

This block sits between a host CPU that issues floppy controller commands and a helper CPU that does the actual sector work against a disk image. When the host posts a command, the sequencer latches the drive, side, track and sector. It then publishes an 8-bit request code that the helper CPU polls. It waits for the helper's completion status, answers with an acknowledge request that carries the helper's result, and waits for the status to clear. Sector data moves between the host and a sector buffer through a byte-wide DMA handshake: `drq` asks for a byte and `dma_ack` consumes one. `dma_done` marks the final byte.

A write is handled in a different order from the other commands. The host first fills the buffer, and only then is the write request posted. `busy` drops at the end of that DMA, so the host sees the command finish early while the helper CPU is still flushing the buffer. A command issued in that window is held and starts once the sequencer is back in READY. A command that arrives while the sequencer is busy, or while another command is already held, is a collision. A collision is fatal: the block enters DEAD, raises `lockup` to stall the host, and freezes a diagnostic snapshot that only a reset clears.

States and their 4-bit codes are READY (0x0), WAIT_CPU (0x1), ENDCOMMAND (0x2), WAIT_CPUWRITE (0x3), XFER (0x4) and DEAD (0xF).

The transitions are:
- READY→WAIT_CPU on a non-write command.
- READY→XFER on a write.
- WAIT_CPU→ENDCOMMAND and WAIT_CPUWRITE→ENDCOMMAND on completion.
- ENDCOMMAND→XFER for read or read-address once the status clears.
- ENDCOMMAND→READY for no-op or write once the status clears.
- XFER→READY after a read-type transfer.
- XFER→WAIT_CPUWRITE after a write transfer.
- Any state→DEAD on a collision.

Top module: `fdc_req_seq`

## Requirements
- R1: After reset the sequencer is in READY with `busy`, `drq`, `dma_done` and `lockup` low, `cpu_request` = 0x00 and `err` = 0.
- R2: A command accepted in READY with `cmd_op` read (0), read-address (2) or no-op (3) sets `busy` one cycle later. In the same cycle it posts `cpu_request` = {code nibble, 2'b00, drive, side}, where the code nibble is 1, 3 or 4 respectively, and enters WAIT_CPU.
- R3: In WAIT_CPU or WAIT_CPUWRITE, a `cpu_status` with bits [7:6] both set causes the next cycle to show `cpu_request` = 0x80 | `cpu_status[5:0]` and state ENDCOMMAND.
- R4: In ENDCOMMAND, a `cpu_status` of zero sets `cpu_request` to 0x00 one cycle later. The state then becomes XFER for a read (SECTOR_BYTES bytes) or a read-address (HEADER_BYTES bytes). For no-op and write it becomes READY, with `busy` low.
- R5: In XFER, `drq` is high until the last byte. Each `dma_ack` consumes one byte. The cycle after the last byte shows `dma_done` high for exactly one cycle and `drq` low. `dma_ack` outside XFER has no effect.
- R6: A write command (`cmd_op` = 1) sets `busy` and `drq` without posting a request. After SECTOR_BYTES bytes, `busy` falls, `cpu_request` = 0x2 nibble with drive and side, and the state is WAIT_CPUWRITE.
- R7: A command arriving while `busy` is low outside READY is held without effect on the outputs. One cycle after READY is reached, it starts as in R2 or R6.
- R8: A command arriving while `busy` is high, or while a held command exists, enters DEAD. DEAD sets `lockup` = 1, `err` = 0xF, `cpu_request` = 0xF0 and `track_rd` = 0. `sector_rd` shows the colliding command's request code. `diag` shows {drq, busy, 2'b00, previous state code}.
- R9: DEAD persists, ignoring commands, status and DMA, until reset.
- R10: Outside DEAD, `track_rd` and `sector_rd` show the running command's track and sector. `diag` shows {drq, busy, 2'b00, current state code}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle host command strobe |
| cmd_op | input | 2 | 0 read, 1 write, 2 read-address, 3 no-op |
| cmd_drive | input | 1 | Drive select |
| cmd_side | input | 1 | Head select |
| cmd_track | input | 8 | Track number |
| cmd_sector | input | 8 | Sector number |
| cpu_status | input | 8 | Helper CPU status; [7:6] both set = done, [5:0] result |
| cpu_request | output | 8 | Request code polled by the helper CPU |
| track_rd | output | 8 | Track index for the helper CPU |
| sector_rd | output | 8 | Sector index for the helper CPU |
| dma_ack | input | 1 | One buffer byte transferred |
| drq | output | 1 | Byte wanted |
| dma_done | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | Host-visible busy |
| err | output | 4 | Error bits, all set in DEAD |
| diag | output | 8 | {drq, busy, 00, state code} |
| lockup | output | 1 | Host stall, high in DEAD |

## Verification
The assertions check invariants on every cycle:
- `drq` never appears without `busy`.
- `dma_done` never lasts two cycles.
- No byte is requested while an acknowledge is posted.
- DEAD always shows its fail outputs and is never left without reset.

Only the bench's scenarios can show the ordering behaviour: that a write releases `busy` before its request is posted, that a command held during the flush starts exactly one cycle after READY, that transfer lengths match the operation, and that the diagnostic snapshot records the state in which the collision happened.

// File: rtl/fdcseq_pkg.sv
package fdcseq_pkg;

    typedef enum logic [3:0] {
        ST_READY      = 4'h0,
        ST_WAIT_CPU   = 4'h1,
        ST_ENDCMD     = 4'h2,
        ST_WAIT_CPUWR = 4'h3,
        ST_XFER       = 4'h4,
        ST_DEAD       = 4'hF
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_RDADDR = 2'd2,
        OP_NOP    = 2'd3
    } op_t;

    typedef struct packed {
        op_t        op;
        logic       drive;
        logic       side;
        logic [7:0] trk;
        logic [7:0] sec;
    } cmd_t;

    localparam logic [7:0] REQ_IDLE = 8'h00;
    localparam logic [1:0] REQ_ACK_TOP = 2'b10;
    localparam logic [7:0] REQ_FAIL = 8'hF0;

    // Request code posted for a command: operation nibble, then drive and side
    function automatic logic [7:0] req_code(cmd_t c);
        logic [3:0] nib;
        unique case (c.op)
            OP_READ:   nib = 4'h1;
            OP_WRITE:  nib = 4'h2;
            OP_RDADDR: nib = 4'h3;
            OP_NOP:    nib = 4'h4;
        endcase
        return {nib, 2'b00, c.drive, c.side};
    endfunction

endpackage

// File: rtl/fdcseq_status_dec.sv
module fdcseq_status_dec #(
    parameter int STAT_W = 8
) (
    input  logic [STAT_W-1:0] status,
    output logic              done,
    output logic              cleared,
    output logic [STAT_W-3:0] result
);
    assign done    = &status[STAT_W-1:STAT_W-2];
    assign cleared = (status == '0);
    assign result  = status[STAT_W-3:0];
endmodule

// File: rtl/fdcseq_cmd_slot.sv
module fdcseq_cmd_slot
    import fdcseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  cmd_t load_cmd,
    input  logic take,
    output logic held,
    output cmd_t held_cmd
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held     <= 1'b0;
            held_cmd <= '0;
        end else if (load) begin
            held     <= 1'b1;
            held_cmd <= load_cmd;
        end else if (take) begin
            held     <= 1'b0;
        end
    end
endmodule

// File: rtl/fdcseq_dma_ctr.sv
module fdcseq_dma_ctr #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic             ack,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            len_q <= len;
        end else if (ack) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign last = ack && (cnt_q == len_q - CNT_W'(1));
endmodule

// File: rtl/fdc_req_seq.sv
module fdc_req_seq
    import fdcseq_pkg::*;
#(
    parameter int SECTOR_BYTES = 256,
    parameter int HEADER_BYTES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_drive,
    input  logic       cmd_side,
    input  logic [7:0] cmd_track,
    input  logic [7:0] cmd_sector,
    input  logic [7:0] cpu_status,
    output logic [7:0] cpu_request,
    output logic [7:0] track_rd,
    output logic [7:0] sector_rd,
    input  logic       dma_ack,
    output logic       drq,
    output logic       dma_done,
    output logic       busy,
    output logic [3:0] err,
    output logic [7:0] diag,
    output logic       lockup
);
    localparam int CNT_W = $clog2(SECTOR_BYTES + 1);
    localparam logic [CNT_W-1:0] LEN_SECTOR = CNT_W'(SECTOR_BYTES);
    localparam logic [CNT_W-1:0] LEN_HEADER = CNT_W'(HEADER_BYTES);

    seq_state_t state_q, state_d;
    cmd_t       cur_q, in_cmd, start_cmd, held_cmd;
    logic [7:0] req_q, dead_code_q, dead_diag_q;
    logic       busy_q, drq_q, done_q;
    logic       held, st_done, st_clear;
    logic [5:0] st_result;
    logic       collide, hold_load, start_go, ack_en, dma_last, ctr_start;
    logic [CNT_W-1:0] ctr_len;

    assign in_cmd = '{op: op_t'(cmd_op), drive: cmd_drive, side: cmd_side,
                      trk: cmd_track, sec: cmd_sector};

    fdcseq_status_dec #(.STAT_W(8)) u_stat (
        .status(cpu_status), .done(st_done), .cleared(st_clear), .result(st_result)
    );

    fdcseq_cmd_slot u_slot (
        .clk(clk), .rst_n(rst_n), .load(hold_load), .load_cmd(in_cmd),
        .take(start_go && held), .held(held), .held_cmd(held_cmd)
    );

    fdcseq_dma_ctr #(.CNT_W(CNT_W)) u_dma (
        .clk(clk), .rst_n(rst_n), .start(ctr_start), .len(ctr_len),
        .ack(ack_en), .last(dma_last)
    );

    // Next-state and event decode
    always_comb begin
        collide   = cmd_valid && (state_q != ST_DEAD) && (busy_q || held);
        hold_load = cmd_valid && !collide && (state_q != ST_READY) && (state_q != ST_DEAD);
        start_go  = (state_q == ST_READY) && !collide && (held || cmd_valid);
        start_cmd = held ? held_cmd : in_cmd;
        ack_en    = dma_ack && (state_q == ST_XFER);
        ctr_start = 1'b0;
        ctr_len   = LEN_SECTOR;
        state_d   = state_q;
        if (collide) begin
            state_d = ST_DEAD;
        end else begin
            unique case (state_q)
                ST_READY: if (start_go) begin
                    if (start_cmd.op == OP_WRITE) begin
                        state_d   = ST_XFER;
                        ctr_start = 1'b1;
                    end else begin
                        state_d = ST_WAIT_CPU;
                    end
                end
                ST_WAIT_CPU, ST_WAIT_CPUWR: if (st_done) state_d = ST_ENDCMD;
                ST_ENDCMD: if (st_clear) begin
                    if (cur_q.op == OP_READ || cur_q.op == OP_RDADDR) begin
                        state_d   = ST_XFER;
                        ctr_start = 1'b1;
                        ctr_len   = (cur_q.op == OP_READ) ? LEN_SECTOR : LEN_HEADER;
                    end else begin
                        state_d = ST_READY;
                    end
                end
                ST_XFER: if (dma_last)
                    state_d = (cur_q.op == OP_WRITE) ? ST_WAIT_CPUWR : ST_READY;
                ST_DEAD: state_d = ST_DEAD;
                default: state_d = ST_DEAD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q       <= REQ_IDLE;
            busy_q      <= 1'b0;
            drq_q       <= 1'b0;
            done_q      <= 1'b0;
            cur_q       <= '0;
            dead_code_q <= '0;
            dead_diag_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (collide) begin
                req_q       <= REQ_FAIL;
                drq_q       <= 1'b0;
                dead_code_q <= req_code(in_cmd);
                dead_diag_q <= {drq_q, busy_q, 2'b00, state_q};
            end else begin
                unique case (state_q)
                    ST_READY: if (start_go) begin
                        cur_q  <= start_cmd;
                        busy_q <= 1'b1;
                        if (start_cmd.op == OP_WRITE) drq_q <= 1'b1;
                        else                          req_q <= req_code(start_cmd);
                    end
                    ST_WAIT_CPU, ST_WAIT_CPUWR:
                        if (st_done) req_q <= {REQ_ACK_TOP, st_result};
                    ST_ENDCMD: if (st_clear) begin
                        req_q <= REQ_IDLE;
                        if (cur_q.op == OP_READ || cur_q.op == OP_RDADDR) drq_q <= 1'b1;
                        else                                              busy_q <= 1'b0;
                    end
                    ST_XFER: if (dma_last) begin
                        drq_q  <= 1'b0;
                        done_q <= 1'b1;
                        busy_q <= 1'b0;
                        if (cur_q.op == OP_WRITE) req_q <= req_code(cur_q);
                    end
                    ST_DEAD: ;
                    default: ;
                endcase
            end
        end
    end

    assign lockup      = (state_q == ST_DEAD);
    assign cpu_request = req_q;
    assign busy        = busy_q;
    assign drq         = drq_q;
    assign dma_done    = done_q;
    assign err         = {4{lockup}};
    assign track_rd    = lockup ? 8'h00 : cur_q.trk;
    assign sector_rd   = lockup ? dead_code_q : cur_q.sec;
    assign diag        = lockup ? dead_diag_q : {drq_q, busy_q, 2'b00, state_q};
endmodule

// File: rtl/fdc_req_seq_chk.sv
module fdc_req_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       drq,
    input logic       dma_done,
    input logic       lockup,
    input logic [7:0] cpu_request,
    input logic [7:0] track_rd,
    input logic [3:0] err
);
    // R5
    drq_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> busy);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> !dma_done);

    // R3
    ack_no_drq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_request[7:6] == 2'b10) |-> !drq);

    // R8
    dead_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |-> (cpu_request == 8'hF0 && track_rd == 8'h00 && err == 4'hF));

    // R9
    dead_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |=> lockup);
endmodule

bind fdc_req_seq fdc_req_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .drq(drq), .dma_done(dma_done),
    .lockup(lockup), .cpu_request(cpu_request), .track_rd(track_rd), .err(err)
);

// File: tb/fdc_req_seq_tb_top.sv
module fdc_req_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       cmd_drive = 1'b0, cmd_side = 1'b0;
    logic [7:0] cmd_track = 8'd0, cmd_sector = 8'd0, cpu_status = 8'd0;
    logic       dma_ack = 1'b0;
    logic [7:0] cpu_request, track_rd, sector_rd, diag;
    logic       drq, dma_done, busy, lockup;
    logic [3:0] err;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_req_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_drive(cmd_drive), .cmd_side(cmd_side), .cmd_track(cmd_track),
        .cmd_sector(cmd_sector), .cpu_status(cpu_status), .cpu_request(cpu_request),
        .track_rd(track_rd), .sector_rd(sector_rd), .dma_ack(dma_ack), .drq(drq),
        .dma_done(dma_done), .busy(busy), .err(err), .diag(diag), .lockup(lockup)
    );

    // {op, drive, side, track, sector, expected request, transfer length}
    localparam int NV = 4;
    localparam logic [36:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b0, 8'd5,  8'd9,   8'h12, 9'd256},
        {2'd2, 1'b0, 1'b1, 8'd40, 8'd1,   8'h31, 9'd6},
        {2'd3, 1'b1, 1'b1, 8'd79, 8'd3,   8'h43, 9'd0},
        {2'd0, 1'b0, 1'b0, 8'd0,  8'd255, 8'h10, 9'd256}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [1:0] op, input logic d, input logic s,
                        input logic [7:0] t, input logic [7:0] sc);
        cmd_valid = 1'b1; cmd_op = op; cmd_drive = d; cmd_side = s;
        cmd_track = t; cmd_sector = sc;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic status(input logic [7:0] v);
        cpu_status = v;
        tick();
    endtask

    task automatic bytes(input int n);
        for (int i = 0; i < n; i++) begin
            if (i == n - 1) chk("R5 drq before last byte", {7'd0, drq}, 8'd1);
            dma_ack = 1'b1;
            tick();
        end
        dma_ack = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd_valid = 1'b0; cpu_status = 8'd0; dma_ack = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 request", cpu_request, 8'h00);
        chk("R1 flags", {4'd0, busy, drq, dma_done, lockup}, 8'h00);
        chk("R1 err", {4'd0, err}, 8'h00);
        chk("R1 state", diag, 8'h00);

        // Table walk: read, read-address, no-op
        for (int v = 0; v < NV; v++) begin
            logic [5:0] res;
            logic [8:0] len;
            res = 6'(v + 3);
            len = VEC[v][8:0];
            send(VEC[v][36:35], VEC[v][34], VEC[v][33], VEC[v][32:25], VEC[v][24:17]);
            chk("R2 request", cpu_request, VEC[v][16:9]);
            chk("R2 busy/state", diag, 8'h41);
            chk("R10 track", track_rd, VEC[v][32:25]);
            chk("R10 sector", sector_rd, VEC[v][24:17]);
            dma_ack = 1'b1; tick(); dma_ack = 1'b0;
            chk("R5 ack outside xfer", {6'd0, drq, dma_done}, 8'h00);
            status({2'b11, res});
            chk("R3 ack request", cpu_request, {2'b10, res});
            chk("R3 state", diag, 8'h42);
            status(8'h00);
            chk("R4 request cleared", cpu_request, 8'h00);
            if (len == 0) begin
                chk("R4 nop done", diag, 8'h00);
            end else begin
                chk("R4 xfer start", diag, 8'hC4);
                bytes(int'(len));
                chk("R5 done pulse", {6'd0, drq, dma_done}, 8'h01);
                chk("R5 back to ready", diag, 8'h00);
                tick();
                chk("R5 done one cycle", {7'd0, dma_done}, 8'h00);
            end
        end

        // R6 write with early busy release, R7 held command
        send(2'd1, 1'b0, 1'b1, 8'd7, 8'd2);
        chk("R6 write start", diag, 8'hC4);
        chk("R6 no request yet", cpu_request, 8'h00);
        bytes(256);
        chk("R6 done pulse", {7'd0, dma_done}, 8'h01);
        chk("R6 busy released", diag, 8'h03);
        chk("R6 write request", cpu_request, 8'h21);
        send(2'd0, 1'b1, 1'b1, 8'd33, 8'd4);
        chk("R7 held, no effect", diag, 8'h03);
        chk("R7 held, request", cpu_request, 8'h21);
        chk("R7 held, track", track_rd, 8'd7);
        status(8'hC5);
        chk("R3 write ack", cpu_request, 8'h85);
        status(8'h00);
        chk("R4 write to ready", diag, 8'h00);
        tick();
        chk("R7 held start", cpu_request, 8'h13);
        chk("R7 held busy", diag, 8'h41);
        chk("R7 held track", track_rd, 8'd33);
        status(8'hC0); status(8'h00); bytes(256);
        chk("R4 read finished", diag, 8'h00);

        // R8 collision while busy
        send(2'd3, 1'b0, 1'b0, 8'd1, 8'd1);
        send(2'd0, 1'b1, 1'b1, 8'd9, 8'd9);
        chk("R8 lockup/err", {3'd0, lockup, err}, 8'h1F);
        chk("R8 fail request", cpu_request, 8'hF0);
        chk("R8 track zero", track_rd, 8'h00);
        chk("R8 sector code", sector_rd, 8'h13);
        chk("R8 diag", diag, 8'h41);
        // R9 everything ignored
        status(8'hC1); status(8'h00);
        send(2'd3, 1'b0, 1'b0, 8'd2, 8'd2);
        dma_ack = 1'b1; tick(); dma_ack = 1'b0;
        chk("R9 still dead", {7'd0, lockup}, 8'h01);
        chk("R9 diag frozen", diag, 8'h41);
        chk("R9 sector frozen", sector_rd, 8'h13);
        do_reset();
        chk("R1 after dead", {4'd0, busy, drq, dma_done, lockup}, 8'h00);

        // R8 second command while one is held
        send(2'd1, 1'b1, 1'b0, 8'd3, 8'd3);
        bytes(256);
        send(2'd3, 1'b0, 1'b0, 8'd4, 8'd4);
        send(2'd2, 1'b0, 1'b1, 8'd5, 8'd5);
        chk("R8 held collision", {7'd0, lockup}, 8'h01);
        chk("R8 held diag", diag, 8'h03);
        chk("R8 held sector", sector_rd, 8'h31);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule